// File: doc/BRIEF.md
# Modified/Invalid Coherence Directory with DMA Service

This block is the home directory for a two-state coherence scheme. Each memory line is either held exclusively by one cache (Modified) or by nobody (Invalid). For each line the directory keeps a state and the identity of the owning cache. It turns cache requests and DMA requests into memory reads and writes, forwards and invalidations sent to the owner, data and acknowledgements to caches, and responses to the DMA engine.

A DMA access to a line that a cache holds is served in two steps. The owner is first told to give the line back. When the returned line arrives, it is sent to the DMA reader, or it is overlaid with the DMA bytes and written to memory. The line becomes Invalid only after memory confirms the write. A line that is busy in any transient step refuses new requests by holding its ready low. The sender retries later and may meanwhile present other requests, so a stalled request never blocks the message that would unblock it.

Each line has its own pending-transaction slot. That slot holds the DMA offset, length and data, and the cache whose writeback is in flight. Only one transaction can be open per line, because slots are filled only from a stable state. At most one event is handled per clock. A memory acknowledgement goes first, then a cache request, then a DMA request. All outputs are single-cycle pulses registered one clock after the event.

Top module: `miDirectory`

## Requirements
- R1: After reset every line is Invalid and no output pulse is raised.
- R2: A GETX (reqKind 0) or GETS (reqKind 1) to an Invalid line is accepted. A memory read of that line follows one cycle later. The memory acknowledgement then yields a cacheData pulse to that requester with the acknowledged data, and the line is Modified with the requester as owner.
- R3: A GETX/GETS to a Modified line is accepted. It produces a forward (fwdInv=0) to the current owner that carries the requester, and the requester becomes the owner.
- R4: A PUTX (reqKind 2) from the owner of a Modified line is accepted. It produces a memory write of its data with all byte enables set. The acknowledgement yields wbAck to that cache, and the line becomes Invalid.
- R5: A DMA read of a Modified line produces an invalidation (fwdInv=1) to the owner for that line, with requester equal to the DIR_ID parameter. The owner's PUTX then yields, in the same cycle, a DMA read response carrying the PUTX data and a full memory write of that data. The acknowledgement yields wbAck to that owner and leaves the line Invalid.
- R6: A DMA write of a Modified line produces an invalidation to the owner. The owner's PUTX yields a full memory write in which byte i (bits 8i+7:8i) is taken from dmaData when dmaOffset <= i < dmaOffset+dmaLen, and from the PUTX data otherwise. Bytes past the line end are dropped. The acknowledgement yields both wbAck to the owner and a DMA write response.
- R7: A DMA read of an Invalid line produces a memory read. The acknowledgement yields a DMA read response with the acknowledged data.
- R8: A DMA write of an Invalid line produces a memory write of dmaData. memReqMask bit i is set exactly for dmaOffset <= i < dmaOffset+dmaLen. The acknowledgement yields a DMA write response.
- R9: A line in a transient state refuses every cache request (ready low, no output, no state change). The exception is a PUTX while the line waits for the returned data of a DMA access. Every DMA request to a non-stable line is refused.
- R10: A PUTX from a cache that does not own the line, in a stable state, is accepted and has no effect.
- R11: While memAckValid is high, both readies are low. When a cache request and a DMA request are both acceptable, only the cache request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Cache request present |
| reqReady | output | 1 | Cache request consumed this cycle |
| reqKind | input | 2 | 0 GETX, 1 GETS, 2 PUTX |
| reqSrc | input | NODE_W | Requesting cache |
| reqLine | input | LINE_W | Line index |
| reqData | input | 8*LINE_BYTES | PUTX line data |
| dmaValid | input | 1 | DMA request present |
| dmaReady | output | 1 | DMA request consumed this cycle |
| dmaWrite | input | 1 | 1 write, 0 read |
| dmaLine | input | LINE_W | Line index |
| dmaOffset | input | OFF_W | First byte within the line |
| dmaLen | input | LEN_W | Byte count |
| dmaData | input | 8*LINE_BYTES | Write bytes, in line position |
| memAckValid | input | 1 | Memory acknowledgement |
| memAckLine | input | LINE_W | Acknowledged line |
| memAckData | input | 8*LINE_BYTES | Read data for a fetch |
| fwdValid | output | 1 | Message to owner |
| fwdInv | output | 1 | 1 invalidation (control size), 0 forwarded GETX |
| fwdDest | output | NODE_W | Owner addressed |
| fwdRequester | output | NODE_W | Requester named in the message |
| fwdLine | output | LINE_W | Line index |
| cacheDataValid | output | 1 | Line data to a cache |
| cacheDataDest | output | NODE_W | Receiving cache |
| cacheDataLine | output | LINE_W | Line index |
| cacheData | output | 8*LINE_BYTES | Line data |
| wbAckValid | output | 1 | Writeback acknowledgement |
| wbAckDest | output | NODE_W | Cache that wrote back |
| wbAckLine | output | LINE_W | Line index |
| memReqValid | output | 1 | Memory request |
| memReqWrite | output | 1 | 1 write, 0 read |
| memReqLine | output | LINE_W | Line index |
| memReqMask | output | LINE_BYTES | Byte enables of a write |
| memReqData | output | 8*LINE_BYTES | Write data |
| dmaRespValid | output | 1 | DMA response |
| dmaRespWrite | output | 1 | 1 write done, 0 read data |
| dmaRespLine | output | LINE_W | Line index |
| dmaRespData | output | 8*LINE_BYTES | Read data |

## Verification
Each line is driven through a different path: a cache fetch, an ownership hand-over, a voluntary writeback, and DMA reads and writes to both owned and unowned lines. This separates the direct memory path from the invalidate-then-merge path. Requests are aimed at lines in every transient state, both alone and together with an acknowledgement or a competing DMA request. This shows that refusals leave no trace and that the priority order holds. The DMA write uses an offset and length that cross the line end, so a wrong clip or byte order in the merge changes visible data.

// File: rtl/miDirPkg.sv
package miDirPkg;

  typedef enum logic [3:0] {
    ST_I, ST_M, ST_IM, ST_MI, ST_ID, ST_IDW,
    ST_DRD, ST_DWR, ST_DRDI, ST_DWRI
  } lineSt_e;

  localparam logic [1:0] KIND_PUTX = 2'd2;

  typedef struct packed {
    logic fwd;
    logic fwdInv;
    logic cacheData;
    logic wbAck;
    logic memRd;
    logic memWr;
    logic memWrDmaMask;
    logic memWrMerge;
    logic dmaRd;
    logic dmaRdFromReq;
    logic dmaWr;
    logic tbeLoad;
    logic tbeOwner;
  } strobe_t;

endpackage

// File: rtl/miDirCtl.sv
module miDirCtl
  import miDirPkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NODE_W    = 2,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              dmaValid,
  input  logic              dmaWrite,
  input  logic [LINE_W-1:0] dmaLine,
  input  logic              memAckValid,
  input  logic [LINE_W-1:0] memAckLine,
  output logic              reqReady,
  output logic              dmaReady,
  output strobe_t           stb,
  output logic [LINE_W-1:0] evLine,
  output logic [NODE_W-1:0] evOwner
);

  lineSt_e           stQ  [NUM_LINES];
  logic [NODE_W-1:0] ownQ [NUM_LINES];

  lineSt_e stNext, cur, dCur;
  logic    upd, setOwn, isPut, fromOwner;

  always_comb begin
    stb       = '0;
    reqReady  = 1'b0;
    dmaReady  = 1'b0;
    upd       = 1'b0;
    setOwn    = 1'b0;
    stNext    = ST_I;
    evLine    = memAckLine;
    cur       = stQ[reqLine];
    dCur      = stQ[dmaLine];
    isPut     = (reqKind == KIND_PUTX);
    fromOwner = (reqSrc == ownQ[reqLine]);
    if (memAckValid) begin
      upd = 1'b1;
      case (stQ[memAckLine])
        ST_IM:   begin stb.cacheData = 1'b1; stNext = ST_M; end
        ST_MI:   stb.wbAck = 1'b1;
        ST_DRDI: stb.wbAck = 1'b1;
        ST_ID:   stb.dmaRd = 1'b1;
        ST_IDW:  stb.dmaWr = 1'b1;
        ST_DWRI: begin stb.wbAck = 1'b1; stb.dmaWr = 1'b1; end
        default: upd = 1'b0;
      endcase
    end else begin
      evLine = reqLine;
      if (reqValid) begin
        case (cur)
          ST_I: begin
            reqReady = 1'b1;
            if (!isPut) begin
              stb.memRd = 1'b1; upd = 1'b1; stNext = ST_IM; setOwn = 1'b1;
            end
          end
          ST_M: begin
            reqReady = 1'b1;
            if (!isPut) begin
              stb.fwd = 1'b1; setOwn = 1'b1;
            end else if (fromOwner) begin
              stb.memWr = 1'b1; stb.tbeOwner = 1'b1; upd = 1'b1; stNext = ST_MI;
            end
          end
          ST_DRD, ST_DWR: begin
            if (isPut) begin
              reqReady = 1'b1;
              if (fromOwner) begin
                stb.memWr = 1'b1; stb.tbeOwner = 1'b1; upd = 1'b1;
                if (cur == ST_DRD) begin
                  stb.dmaRd = 1'b1; stb.dmaRdFromReq = 1'b1; stNext = ST_DRDI;
                end else begin
                  stb.memWrMerge = 1'b1; stNext = ST_DWRI;
                end
              end
            end
          end
          default: ;
        endcase
      end
      if (!reqReady && dmaValid && (dCur == ST_I || dCur == ST_M)) begin
        dmaReady = 1'b1;
        evLine   = dmaLine;
        upd      = 1'b1;
        if (dCur == ST_I) begin
          if (dmaWrite) begin
            stb.memWr = 1'b1; stb.memWrDmaMask = 1'b1; stNext = ST_IDW;
          end else begin
            stb.memRd = 1'b1; stNext = ST_ID;
          end
        end else begin
          stb.fwd = 1'b1; stb.fwdInv = 1'b1; stb.tbeLoad = 1'b1;
          stNext = dmaWrite ? ST_DWR : ST_DRD;
        end
      end
    end
    evOwner = ownQ[evLine];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        stQ[i]  <= ST_I;
        ownQ[i] <= '0;
      end
    end else begin
      if (upd)    stQ[evLine]  <= stNext;
      if (setOwn) ownQ[evLine] <= reqSrc;
    end
  end

endmodule

// File: rtl/miDirDp.sv
module miDirDp
  import miDirPkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 8,
  parameter int NODE_W     = 2,
  parameter int DIR_ID     = 3,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = OFF_W + 1,
  localparam int DATA_W    = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [LINE_W-1:0]     evLine,
  input  logic [NODE_W-1:0]     evOwner,
  input  logic [NODE_W-1:0]     reqSrc,
  input  logic [DATA_W-1:0]     reqData,
  input  logic [OFF_W-1:0]      dmaOffset,
  input  logic [LEN_W-1:0]      dmaLen,
  input  logic [DATA_W-1:0]     dmaData,
  input  logic [DATA_W-1:0]     memAckData,
  output logic                  fwdValid,
  output logic                  fwdInv,
  output logic [NODE_W-1:0]     fwdDest,
  output logic [NODE_W-1:0]     fwdRequester,
  output logic [LINE_W-1:0]     fwdLine,
  output logic                  cacheDataValid,
  output logic [NODE_W-1:0]     cacheDataDest,
  output logic [LINE_W-1:0]     cacheDataLine,
  output logic [DATA_W-1:0]     cacheData,
  output logic                  wbAckValid,
  output logic [NODE_W-1:0]     wbAckDest,
  output logic [LINE_W-1:0]     wbAckLine,
  output logic                  memReqValid,
  output logic                  memReqWrite,
  output logic [LINE_W-1:0]     memReqLine,
  output logic [LINE_BYTES-1:0] memReqMask,
  output logic [DATA_W-1:0]     memReqData,
  output logic                  dmaRespValid,
  output logic                  dmaRespWrite,
  output logic [LINE_W-1:0]     dmaRespLine,
  output logic [DATA_W-1:0]     dmaRespData
);

  logic [OFF_W-1:0]  tOff  [NUM_LINES];
  logic [LEN_W-1:0]  tLen  [NUM_LINES];
  logic [DATA_W-1:0] tData [NUM_LINES];
  logic [NODE_W-1:0] tOwn  [NUM_LINES];

  function automatic logic [LINE_BYTES-1:0] spanMask(input logic [OFF_W-1:0] off,
                                                     input logic [LEN_W-1:0] len);
    int lo, hi;
    lo = int'(off);
    hi = lo + int'(len);
    for (int i = 0; i < LINE_BYTES; i++) spanMask[i] = (i >= lo) && (i < hi);
  endfunction

  logic [LINE_BYTES-1:0] dmaMask, tbeMask;
  logic [DATA_W-1:0]     mergedLine;

  always_comb begin
    dmaMask = spanMask(dmaOffset, dmaLen);
    tbeMask = spanMask(tOff[evLine], tLen[evLine]);
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : gMerge
    assign mergedLine[8*b +: 8] = tbeMask[b] ? tData[evLine][8*b +: 8] : reqData[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (stb.tbeLoad) begin
      tOff[evLine]  <= dmaOffset;
      tLen[evLine]  <= dmaLen;
      tData[evLine] <= dmaData;
    end
    if (stb.tbeOwner) tOwn[evLine] <= reqSrc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0; fwdInv <= 1'b0; fwdDest <= '0; fwdRequester <= '0; fwdLine <= '0;
      cacheDataValid <= 1'b0; cacheDataDest <= '0; cacheDataLine <= '0; cacheData <= '0;
      wbAckValid <= 1'b0; wbAckDest <= '0; wbAckLine <= '0;
      memReqValid <= 1'b0; memReqWrite <= 1'b0; memReqLine <= '0; memReqMask <= '0;
      memReqData <= '0;
      dmaRespValid <= 1'b0; dmaRespWrite <= 1'b0; dmaRespLine <= '0; dmaRespData <= '0;
    end else begin
      fwdValid       <= stb.fwd;
      fwdInv         <= stb.fwdInv;
      fwdDest        <= evOwner;
      fwdRequester   <= stb.fwdInv ? NODE_W'(DIR_ID) : reqSrc;
      fwdLine        <= evLine;
      cacheDataValid <= stb.cacheData;
      cacheDataDest  <= evOwner;
      cacheDataLine  <= evLine;
      cacheData      <= memAckData;
      wbAckValid     <= stb.wbAck;
      wbAckDest      <= tOwn[evLine];
      wbAckLine      <= evLine;
      memReqValid    <= stb.memRd | stb.memWr;
      memReqWrite    <= stb.memWr;
      memReqLine     <= evLine;
      memReqMask     <= stb.memWrDmaMask ? dmaMask : {LINE_BYTES{stb.memWr}};
      memReqData     <= stb.memWrDmaMask ? dmaData : (stb.memWrMerge ? mergedLine : reqData);
      dmaRespValid   <= stb.dmaRd | stb.dmaWr;
      dmaRespWrite   <= stb.dmaWr;
      dmaRespLine    <= evLine;
      dmaRespData    <= stb.dmaRdFromReq ? reqData : memAckData;
    end
  end

endmodule

// File: rtl/miDirectory.sv
module miDirectory
  import miDirPkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 8,
  parameter int NODE_W     = 2,
  parameter int DIR_ID     = 3,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = OFF_W + 1,
  localparam int DATA_W    = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [1:0]            reqKind,
  input  logic [NODE_W-1:0]     reqSrc,
  input  logic [LINE_W-1:0]     reqLine,
  input  logic [DATA_W-1:0]     reqData,
  input  logic                  dmaValid,
  output logic                  dmaReady,
  input  logic                  dmaWrite,
  input  logic [LINE_W-1:0]     dmaLine,
  input  logic [OFF_W-1:0]      dmaOffset,
  input  logic [LEN_W-1:0]      dmaLen,
  input  logic [DATA_W-1:0]     dmaData,
  input  logic                  memAckValid,
  input  logic [LINE_W-1:0]     memAckLine,
  input  logic [DATA_W-1:0]     memAckData,
  output logic                  fwdValid,
  output logic                  fwdInv,
  output logic [NODE_W-1:0]     fwdDest,
  output logic [NODE_W-1:0]     fwdRequester,
  output logic [LINE_W-1:0]     fwdLine,
  output logic                  cacheDataValid,
  output logic [NODE_W-1:0]     cacheDataDest,
  output logic [LINE_W-1:0]     cacheDataLine,
  output logic [DATA_W-1:0]     cacheData,
  output logic                  wbAckValid,
  output logic [NODE_W-1:0]     wbAckDest,
  output logic [LINE_W-1:0]     wbAckLine,
  output logic                  memReqValid,
  output logic                  memReqWrite,
  output logic [LINE_W-1:0]     memReqLine,
  output logic [LINE_BYTES-1:0] memReqMask,
  output logic [DATA_W-1:0]     memReqData,
  output logic                  dmaRespValid,
  output logic                  dmaRespWrite,
  output logic [LINE_W-1:0]     dmaRespLine,
  output logic [DATA_W-1:0]     dmaRespData
);

  strobe_t           stb;
  logic [LINE_W-1:0] evLine;
  logic [NODE_W-1:0] evOwner;

  miDirCtl #(.NUM_LINES(NUM_LINES), .NODE_W(NODE_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqSrc(reqSrc), .reqLine(reqLine),
    .dmaValid(dmaValid), .dmaWrite(dmaWrite), .dmaLine(dmaLine),
    .memAckValid(memAckValid), .memAckLine(memAckLine),
    .reqReady(reqReady), .dmaReady(dmaReady),
    .stb(stb), .evLine(evLine), .evOwner(evOwner)
  );

  miDirDp #(.NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES), .NODE_W(NODE_W),
            .DIR_ID(DIR_ID)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .evLine(evLine), .evOwner(evOwner),
    .reqSrc(reqSrc), .reqData(reqData),
    .dmaOffset(dmaOffset), .dmaLen(dmaLen), .dmaData(dmaData),
    .memAckData(memAckData),
    .fwdValid(fwdValid), .fwdInv(fwdInv), .fwdDest(fwdDest),
    .fwdRequester(fwdRequester), .fwdLine(fwdLine),
    .cacheDataValid(cacheDataValid), .cacheDataDest(cacheDataDest),
    .cacheDataLine(cacheDataLine), .cacheData(cacheData),
    .wbAckValid(wbAckValid), .wbAckDest(wbAckDest), .wbAckLine(wbAckLine),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqLine(memReqLine),
    .memReqMask(memReqMask), .memReqData(memReqData),
    .dmaRespValid(dmaRespValid), .dmaRespWrite(dmaRespWrite),
    .dmaRespLine(dmaRespLine), .dmaRespData(dmaRespData)
  );

endmodule

// File: rtl/miDirCheck.sv
module miDirCheck #(
  parameter int NODE_W = 2,
  parameter int LINE_W = 2,
  parameter int DIR_ID = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqKind,
  input logic [LINE_W-1:0] reqLine,
  input logic              dmaValid,
  input logic              dmaReady,
  input logic [LINE_W-1:0] dmaLine,
  input logic              memAckValid,
  input logic              fwdValid,
  input logic              fwdInv,
  input logic [NODE_W-1:0] fwdRequester,
  input logic [LINE_W-1:0] fwdLine,
  input logic              memReqValid,
  input logic              memReqWrite,
  input logic [LINE_W-1:0] memReqLine
);

  a_r11_ack_first: assert property (@(posedge clk) disable iff (!rstN)
    memAckValid |-> !reqReady && !dmaReady);

  a_r11_cache_first: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !dmaReady);

  a_r9_req_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> reqValid);

  a_r9_dma_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    dmaReady |-> dmaValid);

  a_r2_get_effect: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && reqKind != 2'd2 |=>
      (memReqValid && !memReqWrite && memReqLine == $past(reqLine)) ||
      (fwdValid && !fwdInv && fwdLine == $past(reqLine)));

  a_r5_inv_from_dir: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && fwdInv |-> fwdRequester == NODE_W'(DIR_ID));

  a_r8_dma_effect: assert property (@(posedge clk) disable iff (!rstN)
    dmaReady |=>
      (memReqValid && memReqLine == $past(dmaLine)) ||
      (fwdValid && fwdInv && fwdLine == $past(dmaLine)));

endmodule

bind miDirectory miDirCheck #(.NODE_W(NODE_W), .LINE_W(LINE_W), .DIR_ID(DIR_ID)) u_chk (
  .clk(clk), .rstN(rstN),
  .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind), .reqLine(reqLine),
  .dmaValid(dmaValid), .dmaReady(dmaReady), .dmaLine(dmaLine),
  .memAckValid(memAckValid),
  .fwdValid(fwdValid), .fwdInv(fwdInv), .fwdRequester(fwdRequester), .fwdLine(fwdLine),
  .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqLine(memReqLine)
);

// File: tb/miDirectory_bench.sv
module miDirectory_bench;

  localparam int NL = 4, LB = 8, NW = 2, DID = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic reqValid = 0, dmaValid = 0, dmaWrite = 0, memAckValid = 0;
  logic [1:0] reqKind = 0, reqSrc = 0, reqLine = 0, dmaLine = 0, memAckLine = 0;
  logic [2:0] dmaOffset = 0;
  logic [3:0] dmaLen = 0;
  logic [63:0] reqData = 0, dmaData = 0, memAckData = 0;
  logic reqReady, dmaReady;
  logic fwdValid, fwdInv, cacheDataValid, wbAckValid, memReqValid, memReqWrite;
  logic dmaRespValid, dmaRespWrite;
  logic [1:0] fwdDest, fwdRequester, fwdLine, cacheDataDest, cacheDataLine;
  logic [1:0] wbAckDest, wbAckLine, memReqLine, dmaRespLine;
  logic [7:0] memReqMask;
  logic [63:0] cacheData, memReqData, dmaRespData;

  miDirectory #(.NUM_LINES(NL), .LINE_BYTES(LB), .NODE_W(NW), .DIR_ID(DID)) u_miDirectory (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind), .reqSrc(reqSrc),
    .reqLine(reqLine), .reqData(reqData),
    .dmaValid(dmaValid), .dmaReady(dmaReady), .dmaWrite(dmaWrite), .dmaLine(dmaLine),
    .dmaOffset(dmaOffset), .dmaLen(dmaLen), .dmaData(dmaData),
    .memAckValid(memAckValid), .memAckLine(memAckLine), .memAckData(memAckData),
    .fwdValid(fwdValid), .fwdInv(fwdInv), .fwdDest(fwdDest),
    .fwdRequester(fwdRequester), .fwdLine(fwdLine),
    .cacheDataValid(cacheDataValid), .cacheDataDest(cacheDataDest),
    .cacheDataLine(cacheDataLine), .cacheData(cacheData),
    .wbAckValid(wbAckValid), .wbAckDest(wbAckDest), .wbAckLine(wbAckLine),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqLine(memReqLine),
    .memReqMask(memReqMask), .memReqData(memReqData),
    .dmaRespValid(dmaRespValid), .dmaRespWrite(dmaRespWrite),
    .dmaRespLine(dmaRespLine), .dmaRespData(dmaRespData)
  );

  // reference model: line condition codes
  localparam int S_I = 0, S_M = 1, S_IM = 2, S_MI = 3, S_ID = 4, S_IDW = 5;
  localparam int S_DRD = 6, S_DWR = 7, S_DRDI = 8, S_DWRI = 9;
  int mSt [NL];
  int mOwn [NL];
  int mWb [NL];
  logic [63:0] mDma [NL];
  logic [7:0]  mMask [NL];

  int nChk = 0, nBad = 0;
  bit done = 0;

  logic eFwdV, eFwdInv, eCdV, eWbV, eMemV, eMemW, eDmaV, eDmaW;
  logic [1:0] eFwdDest, eFwdReq, eFwdLine, eCdDest, eCdLine, eWbDest, eWbLine;
  logic [1:0] eMemLine, eDmaLine;
  logic [7:0] eMemMask;
  logic [63:0] eCdData, eMemData, eDmaData;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rangeMask(input logic [2:0] off, input logic [3:0] len);
    logic [15:0] w;
    w = ((16'd1 << len) - 16'd1) << off;
    return w[7:0];
  endfunction

  function automatic logic [63:0] overlay(input logic [63:0] base, input logic [63:0] ins,
                                          input logic [7:0] m);
    logic [63:0] r;
    r = base;
    for (int k = 0; k < 8; k++) if (m[k]) r[8*k +: 8] = ins[8*k +: 8];
    return r;
  endfunction

  task automatic cycle(input string tag);
    logic expRq, expDm, put;
    int l, s;
    expRq = 0; expDm = 0;
    #2;
    eFwdV = 0; eCdV = 0; eWbV = 0; eMemV = 0; eDmaV = 0;
    eMemW = 0; eDmaW = 0; eFwdInv = 0;
    if (memAckValid) begin
      l = int'(memAckLine); s = mSt[l];
      if (s == S_IM) begin
        eCdV = 1; eCdDest = 2'(mOwn[l]); eCdLine = memAckLine; eCdData = memAckData;
        mSt[l] = S_M;
      end else if (s == S_MI || s == S_DRDI || s == S_DWRI) begin
        eWbV = 1; eWbDest = 2'(mWb[l]); eWbLine = memAckLine;
        if (s == S_DWRI) begin eDmaV = 1; eDmaW = 1; eDmaLine = memAckLine; end
        mSt[l] = S_I;
      end else if (s == S_ID || s == S_IDW) begin
        eDmaV = 1; eDmaW = (s == S_IDW); eDmaLine = memAckLine; eDmaData = memAckData;
        mSt[l] = S_I;
      end
    end else begin
      l = int'(reqLine); s = mSt[l]; put = (reqKind == 2'd2);
      if (reqValid) begin
        if (s == S_I) begin
          expRq = 1;
          if (!put) begin
            eMemV = 1; eMemLine = reqLine; mSt[l] = S_IM; mOwn[l] = int'(reqSrc);
          end
        end else if (s == S_M) begin
          expRq = 1;
          if (!put) begin
            eFwdV = 1; eFwdDest = 2'(mOwn[l]); eFwdReq = reqSrc; eFwdLine = reqLine;
            mOwn[l] = int'(reqSrc);
          end else if (int'(reqSrc) == mOwn[l]) begin
            eMemV = 1; eMemW = 1; eMemLine = reqLine; eMemMask = 8'hFF; eMemData = reqData;
            mWb[l] = int'(reqSrc); mSt[l] = S_MI;
          end
        end else if ((s == S_DRD || s == S_DWR) && put) begin
          expRq = 1;
          if (int'(reqSrc) == mOwn[l]) begin
            eMemV = 1; eMemW = 1; eMemLine = reqLine; eMemMask = 8'hFF;
            mWb[l] = int'(reqSrc);
            if (s == S_DRD) begin
              eMemData = reqData; eDmaV = 1; eDmaLine = reqLine; eDmaData = reqData;
              mSt[l] = S_DRDI;
            end else begin
              eMemData = overlay(reqData, mDma[l], mMask[l]);
              mSt[l] = S_DWRI;
            end
          end
        end
      end
      l = int'(dmaLine); s = mSt[l];
      if (!expRq && dmaValid && (s == S_I || s == S_M)) begin
        expDm = 1;
        if (s == S_I) begin
          eMemV = 1; eMemLine = dmaLine; eMemW = dmaWrite;
          if (dmaWrite) begin
            eMemMask = rangeMask(dmaOffset, dmaLen); eMemData = dmaData; mSt[l] = S_IDW;
          end else mSt[l] = S_ID;
        end else begin
          eFwdV = 1; eFwdInv = 1; eFwdDest = 2'(mOwn[l]); eFwdReq = 2'(DID);
          eFwdLine = dmaLine;
          mDma[l] = dmaData; mMask[l] = rangeMask(dmaOffset, dmaLen);
          mSt[l] = dmaWrite ? S_DWR : S_DRD;
        end
      end
    end
    chk(tag, "reqReady", 64'(reqReady), 64'(expRq));
    chk(tag, "dmaReady", 64'(dmaReady), 64'(expDm));
    @(posedge clk);
    #1;
    chk(tag, "fwdValid", 64'(fwdValid), 64'(eFwdV));
    if (eFwdV) begin
      chk(tag, "fwdInv", 64'(fwdInv), 64'(eFwdInv));
      chk(tag, "fwdDest", 64'(fwdDest), 64'(eFwdDest));
      chk(tag, "fwdRequester", 64'(fwdRequester), 64'(eFwdReq));
      chk(tag, "fwdLine", 64'(fwdLine), 64'(eFwdLine));
    end
    chk(tag, "cacheDataValid", 64'(cacheDataValid), 64'(eCdV));
    if (eCdV) begin
      chk(tag, "cacheDataDest", 64'(cacheDataDest), 64'(eCdDest));
      chk(tag, "cacheDataLine", 64'(cacheDataLine), 64'(eCdLine));
      chk(tag, "cacheData", cacheData, eCdData);
    end
    chk(tag, "wbAckValid", 64'(wbAckValid), 64'(eWbV));
    if (eWbV) begin
      chk(tag, "wbAckDest", 64'(wbAckDest), 64'(eWbDest));
      chk(tag, "wbAckLine", 64'(wbAckLine), 64'(eWbLine));
    end
    chk(tag, "memReqValid", 64'(memReqValid), 64'(eMemV));
    if (eMemV) begin
      chk(tag, "memReqWrite", 64'(memReqWrite), 64'(eMemW));
      chk(tag, "memReqLine", 64'(memReqLine), 64'(eMemLine));
      if (eMemW) begin
        chk(tag, "memReqMask", 64'(memReqMask), 64'(eMemMask));
        chk(tag, "memReqData", memReqData, eMemData);
      end
    end
    chk(tag, "dmaRespValid", 64'(dmaRespValid), 64'(eDmaV));
    if (eDmaV) begin
      chk(tag, "dmaRespWrite", 64'(dmaRespWrite), 64'(eDmaW));
      chk(tag, "dmaRespLine", 64'(dmaRespLine), 64'(eDmaLine));
      if (!eDmaW) chk(tag, "dmaRespData", dmaRespData, eDmaData);
    end
    reqValid = 0; dmaValid = 0; memAckValid = 0;
  endtask

  task automatic req(input logic [1:0] k, input logic [1:0] src, input logic [1:0] ln,
                     input logic [63:0] d);
    reqValid = 1; reqKind = k; reqSrc = src; reqLine = ln; reqData = d;
  endtask

  task automatic dma(input logic wr, input logic [1:0] ln, input logic [2:0] off,
                     input logic [3:0] len, input logic [63:0] d);
    dmaValid = 1; dmaWrite = wr; dmaLine = ln; dmaOffset = off; dmaLen = len; dmaData = d;
  endtask

  task automatic ack(input logic [1:0] ln, input logic [63:0] d);
    memAckValid = 1; memAckLine = ln; memAckData = d;
  endtask

  initial begin
    #400000;
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      mSt[i] = S_I; mOwn[i] = 0; mWb[i] = 0; mDma[i] = '0; mMask[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    cycle("R1"); cycle("R1");
    // R2: fetch paths
    req(2'd0, 2'd1, 2'd0, '0);           cycle("R2");
    ack(2'd0, 64'h1111_2222_3333_4444);  cycle("R2");
    req(2'd1, 2'd2, 2'd1, '0);           cycle("R2");
    ack(2'd1, 64'hA5A5_0F0F_5A5A_F0F0);  cycle("R2");
    // R9: line 2 in fetch-wait
    req(2'd0, 2'd0, 2'd2, '0);           cycle("R2");
    req(2'd0, 2'd1, 2'd2, '0);           cycle("R9");
    dma(1'b0, 2'd2, 3'd0, 4'd8, '0);     cycle("R9");
    ack(2'd2, 64'h0102_0304_0506_0708);  cycle("R2");
    // R3: ownership hand-over
    req(2'd0, 2'd2, 2'd0, '0);           cycle("R3");
    // R10: non-owner writebacks
    req(2'd2, 2'd1, 2'd0, 64'hDEAD);     cycle("R10");
    req(2'd2, 2'd0, 2'd3, 64'hBEEF);     cycle("R10");
    // R5: DMA read of owned line
    dma(1'b0, 2'd0, 3'd0, 4'd8, '0);     cycle("R5");
    req(2'd0, 2'd1, 2'd0, '0);           cycle("R9");
    dma(1'b1, 2'd0, 3'd1, 4'd2, '1);     cycle("R9");
    req(2'd2, 2'd2, 2'd0, 64'hCAFE_F00D_1234_5678); cycle("R5");
    req(2'd2, 2'd2, 2'd0, 64'h0);        cycle("R9");
    ack(2'd0, '0);                       cycle("R5");
    req(2'd0, 2'd0, 2'd0, '0);           cycle("R5");
    ack(2'd0, 64'h7777);                 cycle("R2");
    // R6: DMA write of owned line, crosses the line end
    dma(1'b1, 2'd1, 3'd5, 4'd6, 64'hCCDD_EEFF_1122_3344); cycle("R6");
    req(2'd2, 2'd2, 2'd1, 64'h8877_6655_4433_2211); cycle("R6");
    dma(1'b0, 2'd1, 3'd0, 4'd8, '0);     cycle("R9");
    ack(2'd1, '0);                       cycle("R6");
    // R4: voluntary writeback
    req(2'd2, 2'd0, 2'd2, 64'h0F1E_2D3C_4B5A_6978); cycle("R4");
    ack(2'd2, '0);                       cycle("R4");
    // R7 and R8: unowned lines
    dma(1'b0, 2'd2, 3'd0, 4'd8, '0);     cycle("R7");
    ack(2'd2, 64'h5555_AAAA_3333_CCCC);  cycle("R7");
    dma(1'b1, 2'd3, 3'd2, 4'd3, 64'h9999_8888_7777_6666); cycle("R8");
    ack(2'd3, '0);                       cycle("R8");
    // R11: priority
    req(2'd0, 2'd1, 2'd3, '0);           cycle("R11");
    ack(2'd3, 64'h4242); req(2'd0, 2'd2, 2'd2, '0); dma(1'b0, 2'd1, 3'd0, 4'd8, '0);
    cycle("R11");
    req(2'd0, 2'd2, 2'd2, '0); dma(1'b0, 2'd1, 3'd0, 4'd8, '0); cycle("R11");
    dma(1'b0, 2'd1, 3'd0, 4'd8, '0);     cycle("R11");
    ack(2'd2, 64'h1357);                 cycle("R11");
    ack(2'd1, 64'h2468);                 cycle("R11");
    cycle("R1");
    done = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule